// File: doc/BRIEF.md
# Flash Device Reset and Output Controller

This block is the control side of a parallel NOR-style memory device. It decides when the data bus is driven, shows whether an embedded program or erase is running through an active-high ready/busy output, and keeps the read mode register. That register selects either array data or the internal identification byte. A program or erase is modelled as a countdown whose length is a parameter. Array contents, full command decoding and sector maps belong to the neighbouring blocks.

The active-low hardware reset input is qualified by a counter. A low level shorter than the minimum pulse width leaves operations and mode untouched, but the bus is tristated and accesses are refused for as long as the pin is low. A qualified pulse aborts any running operation and returns the mode to array read. It then starts a recovery period whose length depends on whether an operation was running. In the running case the busy output stays asserted for the whole recovery. After release, a further hold-off must pass before reads are served again. An aborted operation leaves a sticky flag that tells the host to reissue it.

Top module: `flash_rst_ctrl`

## Requirements
- R1: After the synchronous system reset, `ry_by` is 1, `autosel_mode` is 0 and `op_interrupted` is 0.
- R2: `dq_oe` is 1 only while `ce_n`=0, `oe_n`=0, `hw_rst_n`=1 and no reset recovery or release hold-off is pending. `oe_n`=1 or `ce_n`=1 forces it to 0.
- R3: In array mode `dq_out` equals `array_data`. In autoselect mode `dq_out[7:0]` is `ID_CODE` and the upper bits are 0.
- R4: A command is accepted on a clock edge where `cmd_valid`=1, `ce_n`=0, access is allowed and no operation or recovery is active. Codes: 0 = array read mode, 1 = autoselect mode, 2 = program, 3 = erase. Program holds `ry_by` at 0 for PROG_CYC cycles and erase holds it at 0 for ERASE_CYC cycles, both counted from the cycle after the accepting edge.
- R5: Raising `ce_n` during a program or erase does not shorten it.
- R6: While `hw_rst_n`=0, `dq_oe` is 0 and commands are not accepted.
- R7: A low on `hw_rst_n` lasting fewer than TRP consecutive cycles changes neither the running operation, the mode nor the flag. After its release no hold-off applies.
- R8: When `hw_rst_n` has been low for TRP cycles during a program or erase, the operation is aborted, `op_interrupted` is set and the mode returns to array read. `ry_by` stays 0 for TREADY_OP cycles after the abort edge, and accesses stay blocked for the same time.
- R9: A qualified reset while idle leaves `ry_by` at 1, returns the mode to array read, and blocks accesses for TREADY_IDLE cycles after the abort edge.
- R10: After a qualified reset, reads are served again only TRH cycles after `hw_rst_n` is first sampled high.
- R11: `op_interrupted` is cleared by the next accepted command.
- R12: Commands presented while an operation runs are ignored.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high system reset |
| ce_n | input | 1 | Chip enable, active low |
| oe_n | input | 1 | Output enable, active low |
| hw_rst_n | input | 1 | Hardware reset pin, active low |
| cmd_valid | input | 1 | Command strobe |
| cmd_opc | input | 2 | Command code (see R4) |
| array_data | input | DW | Data read from the array |
| dq_oe | output | 1 | Data bus drive enable |
| dq_out | output | DW | Data presented on the bus |
| ry_by | output | 1 | 1 = ready, 0 = busy |
| autosel_mode | output | 1 | 1 = autoselect read mode |
| op_interrupted | output | 1 | Sticky flag for an aborted operation |

## Verification
`dq_oe` and `dq_out` are combinational from the inputs and the registered state, so they are checked in the same half cycle that the inputs change. Mode, flag and busy changes appear one edge after the accepting or aborting edge. Every duration is checked on both sides of its boundary: the abort edge falls on the TRP-th low sample, busy ends exactly PROG_CYC, ERASE_CYC or TREADY_OP edges later, and the hold-off ends TRH edges after the first high sample. Inputs change and outputs are sampled only at falling edges, so each expected value is taken at a known count of rising edges.

// File: rtl/frc_pkg.sv
package frc_pkg;

    typedef enum logic [1:0] {
        OPC_READ    = 2'd0,
        OPC_AUTOSEL = 2'd1,
        OPC_PROG    = 2'd2,
        OPC_ERASE   = 2'd3
    } opc_e;

    typedef enum logic [1:0] {
        ST_IDLE  = 2'd0,
        ST_BUSY  = 2'd1,
        ST_RECOV = 2'd2
    } op_state_e;

    typedef enum logic {
        MODE_ARRAY   = 1'b0,
        MODE_AUTOSEL = 1'b1
    } rd_mode_e;

    function automatic int unsigned max2(int unsigned a, int unsigned b);
        return (a > b) ? a : b;
    endfunction

    function automatic int unsigned cnt_width(int unsigned n);
        return (n < 2) ? 1 : $clog2(n + 1);
    endfunction

endpackage

// File: rtl/frc_pulse_qual.sv
module frc_pulse_qual
    import frc_pkg::*;
#(
    parameter int unsigned TRP = 4,
    parameter int unsigned TRH = 3
) (
    input  logic clk,
    input  logic rst,
    input  logic hw_rst_n,
    output logic abort,
    output logic rh_wait
);
    localparam int unsigned LW = cnt_width(TRP);
    localparam int unsigned HW = cnt_width(TRH);

    logic [LW-1:0] lo_cnt;
    logic [HW-1:0] rh_cnt;

    // Qualified pulse: this edge is the TRP-th consecutive low sample
    assign abort   = !hw_rst_n && (lo_cnt == LW'(TRP - 1));
    assign rh_wait = (rh_cnt != '0);

    always_ff @(posedge clk) begin
        if (rst) begin
            lo_cnt <= '0;
            rh_cnt <= '0;
        end else begin
            if (hw_rst_n)
                lo_cnt <= '0;
            else if (lo_cnt != LW'(TRP))
                lo_cnt <= lo_cnt + 1'b1;

            if (abort)
                rh_cnt <= HW'(TRH);
            else if (hw_rst_n && rh_cnt != '0)
                rh_cnt <= rh_cnt - 1'b1;
        end
    end
endmodule

// File: rtl/frc_op_engine.sv
module frc_op_engine
    import frc_pkg::*;
#(
    parameter int unsigned PROG_CYC    = 12,
    parameter int unsigned ERASE_CYC   = 30,
    parameter int unsigned TREADY_OP   = 20,
    parameter int unsigned TREADY_IDLE = 6
) (
    input  logic      clk,
    input  logic      rst,
    input  logic      abort,
    input  logic      start,
    input  logic      start_erase,
    output op_state_e state,
    output logic      busy_flag
);
    localparam int unsigned MAXC = max2(max2(PROG_CYC, ERASE_CYC), max2(TREADY_OP, TREADY_IDLE));
    localparam int unsigned CW   = cnt_width(MAXC);

    logic [CW-1:0] cnt;
    logic          rec_op;
    logic          from_op;

    assign from_op   = (state == ST_BUSY) || (state == ST_RECOV && rec_op);
    assign busy_flag = from_op;

    always_ff @(posedge clk) begin
        if (rst) begin
            state  <= ST_IDLE;
            cnt    <= '0;
            rec_op <= 1'b0;
        end else if (abort) begin
            state  <= ST_RECOV;
            rec_op <= from_op;
            cnt    <= from_op ? CW'(TREADY_OP - 1) : CW'(TREADY_IDLE - 1);
        end else begin
            unique case (state)
                ST_IDLE: begin
                    if (start) begin
                        state <= ST_BUSY;
                        cnt   <= start_erase ? CW'(ERASE_CYC - 1) : CW'(PROG_CYC - 1);
                    end
                end
                ST_BUSY, ST_RECOV: begin
                    if (cnt == '0) begin
                        state  <= ST_IDLE;
                        rec_op <= 1'b0;
                    end else begin
                        cnt <= cnt - 1'b1;
                    end
                end
                default: state <= ST_IDLE;
            endcase
        end
    end
endmodule

// File: rtl/frc_mode_reg.sv
module frc_mode_reg
    import frc_pkg::*;
(
    input  logic     clk,
    input  logic     rst,
    input  logic     abort,
    input  logic     op_running,
    input  logic     cmd_acc,
    input  opc_e     opc,
    output rd_mode_e mode,
    output logic     interrupted
);
    always_ff @(posedge clk) begin
        if (rst) begin
            mode        <= MODE_ARRAY;
            interrupted <= 1'b0;
        end else if (abort) begin
            mode <= MODE_ARRAY;
            if (op_running)
                interrupted <= 1'b1;
        end else if (cmd_acc) begin
            interrupted <= 1'b0;
            if (opc == OPC_READ)
                mode <= MODE_ARRAY;
            else if (opc == OPC_AUTOSEL)
                mode <= MODE_AUTOSEL;
        end
    end
endmodule

// File: rtl/flash_rst_ctrl.sv
module flash_rst_ctrl
    import frc_pkg::*;
#(
    parameter int unsigned DW          = 16,
    parameter int unsigned TRP         = 4,
    parameter int unsigned TREADY_OP   = 20,
    parameter int unsigned TREADY_IDLE = 6,
    parameter int unsigned TRH         = 3,
    parameter int unsigned PROG_CYC    = 12,
    parameter int unsigned ERASE_CYC   = 30,
    parameter logic [7:0]  ID_CODE     = 8'hA7
) (
    input  logic          clk,
    input  logic          rst,
    input  logic          ce_n,
    input  logic          oe_n,
    input  logic          hw_rst_n,
    input  logic          cmd_valid,
    input  logic [1:0]    cmd_opc,
    input  logic [DW-1:0] array_data,
    output logic          dq_oe,
    output logic [DW-1:0] dq_out,
    output logic          ry_by,
    output logic          autosel_mode,
    output logic          op_interrupted
);
    localparam int unsigned UPW = (DW > 8) ? DW - 8 : 1;

    opc_e      opc;
    op_state_e state;
    rd_mode_e  mode;
    logic      abort, rh_wait, busy_flag;
    logic      access_ok, cmd_acc, start, start_erase;

    assign opc         = opc_e'(cmd_opc);
    assign access_ok   = hw_rst_n && !rh_wait && (state != ST_RECOV);
    assign cmd_acc     = cmd_valid && !ce_n && access_ok && (state == ST_IDLE);
    assign start       = cmd_acc && (opc == OPC_PROG || opc == OPC_ERASE);
    assign start_erase = (opc == OPC_ERASE);

    frc_pulse_qual #(.TRP(TRP), .TRH(TRH)) u_qual (
        .clk      (clk),
        .rst      (rst),
        .hw_rst_n (hw_rst_n),
        .abort    (abort),
        .rh_wait  (rh_wait)
    );

    frc_op_engine #(
        .PROG_CYC    (PROG_CYC),
        .ERASE_CYC   (ERASE_CYC),
        .TREADY_OP   (TREADY_OP),
        .TREADY_IDLE (TREADY_IDLE)
    ) u_eng (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .start       (start),
        .start_erase (start_erase),
        .state       (state),
        .busy_flag   (busy_flag)
    );

    frc_mode_reg u_mode (
        .clk         (clk),
        .rst         (rst),
        .abort       (abort),
        .op_running  (state == ST_BUSY),
        .cmd_acc     (cmd_acc),
        .opc         (opc),
        .mode        (mode),
        .interrupted (op_interrupted)
    );

    assign dq_oe        = access_ok && !ce_n && !oe_n;
    assign ry_by        = !busy_flag;
    assign autosel_mode = (mode == MODE_AUTOSEL);

    generate
        if (DW > 8) begin : g_wide
            assign dq_out = (mode == MODE_AUTOSEL) ? {UPW'(0), ID_CODE} : array_data;
        end else begin : g_narrow
            assign dq_out = (mode == MODE_AUTOSEL) ? ID_CODE[DW-1:0] : array_data;
        end
    endgenerate
endmodule

// File: rtl/frc_checker.sv
module frc_checker (
    input logic       clk,
    input logic       rst,
    input logic       ce_n,
    input logic       oe_n,
    input logic       hw_rst_n,
    input logic       cmd_valid,
    input logic [1:0] cmd_opc,
    input logic       dq_oe,
    input logic       ry_by,
    input logic       autosel_mode,
    input logic       op_interrupted
);
    assert_oe_gate_R2: assert property (@(posedge clk) disable iff (rst)
        (oe_n || ce_n) |-> !dq_oe);

    assert_pin_tristate_R6: assert property (@(posedge clk) disable iff (rst)
        !hw_rst_n |-> !dq_oe);

    assert_busy_by_cmd_R4: assert property (@(posedge clk) disable iff (rst)
        $fell(ry_by) |-> $past(cmd_valid && !ce_n && hw_rst_n));

    assert_flag_set_R8: assert property (@(posedge clk) disable iff (rst)
        $rose(op_interrupted) |-> $past(!hw_rst_n && !ry_by));

    assert_flag_clear_R11: assert property (@(posedge clk) disable iff (rst)
        $fell(op_interrupted) |-> $past(cmd_valid && !ce_n && hw_rst_n));

    assert_autosel_entry_R3: assert property (@(posedge clk) disable iff (rst)
        $rose(autosel_mode) |-> $past(cmd_valid && cmd_opc == 2'd1 && hw_rst_n));

    assert_mode_exit_R9: assert property (@(posedge clk) disable iff (rst)
        $fell(autosel_mode) |-> $past(!hw_rst_n || (cmd_valid && cmd_opc == 2'd0)));
endmodule

bind flash_rst_ctrl frc_checker u_frc_checker (
    .clk            (clk),
    .rst            (rst),
    .ce_n           (ce_n),
    .oe_n           (oe_n),
    .hw_rst_n       (hw_rst_n),
    .cmd_valid      (cmd_valid),
    .cmd_opc        (cmd_opc),
    .dq_oe          (dq_oe),
    .ry_by          (ry_by),
    .autosel_mode   (autosel_mode),
    .op_interrupted (op_interrupted)
);

// File: tb/flash_rst_ctrl_tb.sv
module flash_rst_ctrl_tb;
    localparam int unsigned DW = 16, TRP = 4, TREADY_OP = 20, TREADY_IDLE = 6, TRH = 3;
    localparam int unsigned PROG_CYC = 12, ERASE_CYC = 30;
    localparam logic [7:0] ID_CODE = 8'hA7;

    // {ce_n, oe_n, expected dq_oe, array data}
    localparam int NV = 6;
    localparam logic [18:0] VEC [NV] = '{
        {1'b0, 1'b0, 1'b1, 16'h1234},
        {1'b0, 1'b1, 1'b0, 16'hBEEF},
        {1'b1, 1'b0, 1'b0, 16'h5555},
        {1'b1, 1'b1, 1'b0, 16'h0F0F},
        {1'b0, 1'b0, 1'b1, 16'hFFFF},
        {1'b0, 1'b0, 1'b1, 16'h0000}
    };

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic ce_n = 1'b1, oe_n = 1'b1, hw_rst_n = 1'b1, cmd_valid = 1'b0;
    logic [1:0] cmd_opc = 2'd0;
    logic [DW-1:0] array_data = '0;
    logic dq_oe, ry_by, autosel_mode, op_interrupted;
    logic [DW-1:0] dq_out;
    int checks = 0, fails = 0;
    bit done = 1'b0;

    always #2.5 clk = ~clk;

    flash_rst_ctrl #(
        .DW(DW), .TRP(TRP), .TREADY_OP(TREADY_OP), .TREADY_IDLE(TREADY_IDLE),
        .TRH(TRH), .PROG_CYC(PROG_CYC), .ERASE_CYC(ERASE_CYC), .ID_CODE(ID_CODE)
    ) u_dut (
        .clk(clk), .rst(rst), .ce_n(ce_n), .oe_n(oe_n), .hw_rst_n(hw_rst_n),
        .cmd_valid(cmd_valid), .cmd_opc(cmd_opc), .array_data(array_data),
        .dq_oe(dq_oe), .dq_out(dq_out), .ry_by(ry_by),
        .autosel_mode(autosel_mode), .op_interrupted(op_interrupted)
    );

    task automatic step(int n);
        repeat (n) @(negedge clk);
    endtask

    task automatic chk(logic ok, string tag, logic [31:0] act, logic [31:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%0h expected=%0h", tag, act, exp);
        end
    endtask

    task automatic eq(string tag, logic [31:0] act, logic [31:0] exp);
        chk(act === exp, tag, act, exp);
    endtask

    task automatic issue(logic [1:0] op);
        ce_n      = 1'b0;
        cmd_valid = 1'b1;
        cmd_opc   = op;
        step(1);
        cmd_valid = 1'b0;
    endtask

    initial begin
        repeat (50000) @(posedge clk);
        if (!done) begin
            checks++;
            fails++;
            $display("FAIL watchdog actual=%0h expected=%0h", 0, 1);
            $display("%0d/%0d checks passed", checks - fails, checks);
            $finish;
        end
    end

    initial begin
        step(3);
        rst = 1'b0;
        step(1);
        eq("R1 ry_by", ry_by, 1);
        eq("R1 autosel", autosel_mode, 0);
        eq("R1 interrupted", op_interrupted, 0);

        // table walk: output gating and array data path
        for (int i = 0; i < NV; i++) begin
            ce_n = VEC[i][18];
            oe_n = VEC[i][17];
            array_data = VEC[i][15:0];
            #1;
            eq("R2 dq_oe", dq_oe, VEC[i][16]);
            if (VEC[i][16]) eq("R3 array data", dq_out, VEC[i][15:0]);
            step(1);
        end

        // autoselect entry and identification byte
        issue(2'd1);
        eq("R4 autosel entry", autosel_mode, 1);
        oe_n = 1'b0;
        array_data = 16'h1234;
        #1;
        eq("R3 id code", dq_out, {8'h00, ID_CODE});

        // program; command during busy ignored; short pulse ignored
        issue(2'd2);
        eq("R4 program busy", ry_by, 0);
        issue(2'd0);
        eq("R12 cmd ignored while busy", autosel_mode, 1);
        hw_rst_n = 1'b0;
        #1;
        eq("R6 tristate while low", dq_oe, 0);
        step(TRP - 1);
        hw_rst_n = 1'b1;
        #1;
        eq("R7 no holdoff after short pulse", dq_oe, 1);
        step(PROG_CYC - 5);
        eq("R7 still busy", ry_by, 0);
        step(1);
        eq("R4 program length", ry_by, 1);
        eq("R7 mode kept", autosel_mode, 1);
        eq("R7 no flag", op_interrupted, 0);

        // qualified pulse during program
        issue(2'd2);
        step(1);
        hw_rst_n = 1'b0;
        step(TRP);
        eq("R8 flag set", op_interrupted, 1);
        eq("R8 mode to array", autosel_mode, 0);
        eq("R8 busy held", ry_by, 0);
        hw_rst_n = 1'b1;
        step(TREADY_OP - 1);
        eq("R8 busy before recovery end", ry_by, 0);
        eq("R8 access blocked", dq_oe, 0);
        step(1);
        eq("R8 ready after recovery", ry_by, 1);
        eq("R8 access restored", dq_oe, 1);

        issue(2'd0);
        eq("R11 flag cleared", op_interrupted, 0);

        // idle qualified pulse with command attempt while low
        issue(2'd1);
        hw_rst_n  = 1'b0;
        cmd_valid = 1'b1;
        cmd_opc   = 2'd2;
        step(1);
        cmd_valid = 1'b0;
        eq("R6 command ignored while low", ry_by, 1);
        step(TRP - 1);
        eq("R9 mode to array", autosel_mode, 0);
        eq("R9 ready stays high", ry_by, 1);
        eq("R9 no flag", op_interrupted, 0);
        step(8);
        hw_rst_n = 1'b1;
        step(TRH - 1);
        eq("R10 holdoff active", dq_oe, 0);
        step(1);
        eq("R10 holdoff over", dq_oe, 1);

        // idle recovery outlasts the release hold-off
        hw_rst_n = 1'b0;
        step(TRP);
        hw_rst_n = 1'b1;
        step(TREADY_IDLE - 1);
        eq("R9 recovery blocks access", dq_oe, 0);
        step(1);
        eq("R9 access after recovery", dq_oe, 1);

        // erase with chip deselected
        issue(2'd3);
        ce_n = 1'b1;
        eq("R4 erase busy", ry_by, 0);
        step(ERASE_CYC - 1);
        eq("R5 erase continues deselected", ry_by, 0);
        eq("R2 deselected tristate", dq_oe, 0);
        step(1);
        eq("R5 erase length", ry_by, 1);

        done = 1'b1;
        $display("%0d/%0d checks passed", checks - fails, checks);
        $finish;
    end
endmodule